// File: doc/BRIEF.md
# Display Lane Test Pattern Generator

This block supplies one 10-bit word per clock to a single lane of a serial display link while the lane is being brought up or characterised. A one-hot source selector picks what reaches the lane: a constant zero word, the normal encoded data arriving from upstream, a word drawn from a pseudo-random bit sequence, or a word taken from a programmable 80-bit pattern that rotates through eight 10-bit groups.

The pseudo-random generator offers four standard polynomials and three output widths: 1, 8 or 10 fresh bits per word. It also has an idle width that holds the sequence still. The rotating pattern can hold each group for 1 to 8 clocks. Both generators have their own enables and run whether or not the selector is currently showing them. Dropping an enable returns that generator to its start point. The output word is registered, so every source reaches `tx_word` one clock after it is presented.

Top module: `lane_pattern_gen`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it is released, `tx_word` is zero. The random generator is at its all-ones seed and the rotating pattern is at group 0.
- R2: `tx_word` takes its value one clock after the selector is sampled. The `src_sel` codes are: 3'b000 gives zero, 3'b001 gives `norm_data`, 3'b010 gives the random word and 3'b100 gives the rotating-pattern word. Every other code gives zero.
- R3: `prbs_mode` chooses the polynomial: 0 is x^11+x^9+1, 1 is x^15+x^14+1, 2 is x^7+x^6+1 and 3 is x^31+x^28+1. The serial stream obeys b[k] = b[k-L] ^ b[k-T], where L is the degree and T is the middle term, and every b with a negative index counts as 1. Within a word, the bits fill from bit 0 upward in stream order.
- R4: `prbs_width` chooses how many bits each word takes: 0 takes none and outputs zero, 1 takes 8 into [7:0], 2 takes 1 into [0] and 3 takes 10. Unused upper bits are zero, and the stream advances by exactly the number of bits taken.
- R5: While `prbs_en` is low, the random word is zero and the generator reseeds, so the first word after an enable starts at b[0].
- R6: Group g (0 to 7) of the rotating pattern is `shift_pat[79-10g : 70-10g]`. Groups go out in order 0, 1, ... 7 and then wrap back to 0.
- R7: With `shift_rep` = r, each group stays on the output for r+1 consecutive clocks.
- R8: While `shift_en` is low, the rotating-pattern word is zero and the pattern returns to group 0 with a fresh hold count.
- R9: Each generator advances on its own enable, whatever the selector shows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| norm_data | input | 10 | Normal encoded lane data |
| src_sel | input | 3 | One-hot output source selector |
| prbs_en | input | 1 | Random generator enable |
| prbs_mode | input | 2 | Polynomial select |
| prbs_width | input | 2 | Random bits per word select |
| shift_en | input | 1 | Rotating pattern enable |
| shift_rep | input | 3 | Clocks per group, minus one |
| shift_pat | input | 80 | Rotating pattern, group 0 in the top ten bits |
| tx_word | output | 10 | Registered lane word |

## Verification
The bench compares every polynomial at every width against a stream it builds from the recurrence. A wrong tap, a reversed bit order inside the word, or an advance that does not match the width shows up as a mismatch in the first words. An idle interval followed by a switch to full width catches a generator that keeps running while idle. An unselected run followed by selection catches a generator that only steps when it is shown. The rotating pattern is run with hold counts of 0, 2 and 7 across the wrap from group 7 to group 0, which exposes off-by-one holds and reversed group order. Reserved selector codes and disable-then-reenable sequences catch leaks from a stale source and a pattern that does not restart at group 0.

// File: rtl/lpg_pkg.sv
`timescale 1ns/1ps
package lpg_pkg;
  localparam int WORD_W = 10;
  localparam int LFSR_W = 31;

  typedef enum logic [2:0] {
    SRC_ZERO  = 3'b000,
    SRC_NORM  = 3'b001,
    SRC_PRBS  = 3'b010,
    SRC_SHIFT = 3'b100
  } src_e;

  typedef enum logic [1:0] {
    POLY_11 = 2'd0,
    POLY_15 = 2'd1,
    POLY_7  = 2'd2,
    POLY_31 = 2'd3
  } poly_e;

  typedef enum logic [1:0] {
    WID_IDLE = 2'd0,
    WID_8    = 2'd1,
    WID_1    = 2'd2,
    WID_10   = 2'd3
  } wid_e;

  typedef struct packed {
    logic [LFSR_W-1:0] state;
    logic [WORD_W-1:0] word;
  } prbs_res_t;

  // degree of the selected polynomial
  function automatic int poly_len(poly_e m);
    case (m)
      POLY_11: return 11;
      POLY_15: return 15;
      POLY_7:  return 7;
      default: return 31;
    endcase
  endfunction

  // middle term of the selected polynomial
  function automatic int poly_tap(poly_e m);
    case (m)
      POLY_11: return 9;
      POLY_15: return 14;
      POLY_7:  return 6;
      default: return 28;
    endcase
  endfunction

  // fresh bits consumed per output word
  function automatic int wid_bits(wid_e w);
    case (w)
      WID_8:   return 8;
      WID_1:   return 1;
      WID_10:  return WORD_W;
      default: return 0;
    endcase
  endfunction

  // step a Fibonacci register nbits times; bit i of the word is the i-th new bit
  function automatic prbs_res_t prbs_run(logic [LFSR_W-1:0] s, poly_e m, int nbits);
    prbs_res_t r;
    logic fb;
    logic [LFSR_W-1:0] msk;
    int len;
    int tap;
    len = poly_len(m);
    tap = poly_tap(m);
    for (int j = 0; j < LFSR_W; j++) msk[j] = (j < len);
    r.state = s;
    r.word  = '0;
    for (int i = 0; i < WORD_W; i++) begin
      if (i < nbits) begin
        fb = r.state[len-1] ^ r.state[tap-1];
        r.word[i] = fb;
        r.state = {r.state[LFSR_W-2:0], fb} & msk;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/lpg_prbs.sv
`timescale 1ns/1ps
module lpg_prbs
  import lpg_pkg::*;
#(
  parameter int WORD_W_P = WORD_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en_i,
  input  logic [1:0]           mode_i,
  input  logic [1:0]           width_i,
  output logic [WORD_W_P-1:0]  word_o,
  output logic [LFSR_W-1:0]    state_o,
  output logic                 step_o
);
  logic [LFSR_W-1:0] state_q;
  prbs_res_t         nxt;
  int                nb;

  always_comb begin
    nb  = wid_bits(wid_e'(width_i));
    nxt = prbs_run(state_q, poly_e'(mode_i), nb);
  end

  assign word_o  = en_i ? WORD_W_P'(nxt.word) : '0;
  assign step_o  = en_i && (wid_e'(width_i) != WID_IDLE);
  assign state_o = state_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     state_q <= '1;
    else if (!en_i) state_q <= '1;
    else            state_q <= nxt.state;
  end
endmodule

// File: rtl/lpg_shift.sv
`timescale 1ns/1ps
module lpg_shift #(
  parameter int WORD_W_P = 10,
  parameter int GROUPS   = 8,
  parameter int REP_W    = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         en_i,
  input  logic [REP_W-1:0]             rep_i,
  input  logic [WORD_W_P*GROUPS-1:0]   pat_i,
  output logic [WORD_W_P-1:0]          word_o,
  output logic [$clog2(GROUPS)-1:0]    idx_o,
  output logic [REP_W-1:0]             cnt_o,
  output logic                         adv_o
);
  localparam int PAT_W = WORD_W_P * GROUPS;
  localparam int IDX_W = $clog2(GROUPS);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(GROUPS - 1);

  logic [WORD_W_P-1:0] grp [GROUPS];
  logic [IDX_W-1:0]    idx_q;
  logic [REP_W-1:0]    cnt_q;

  // group 0 sits in the top bits of the pattern
  for (genvar g = 0; g < GROUPS; g++) begin : g_slice
    assign grp[g] = pat_i[PAT_W-1-g*WORD_W_P -: WORD_W_P];
  end

  assign adv_o  = en_i && (cnt_q >= rep_i);
  assign word_o = en_i ? grp[idx_q] : '0;
  assign idx_o  = idx_q;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !en_i) begin
      idx_q <= '0;
      cnt_q <= '0;
    end else if (adv_o) begin
      cnt_q <= '0;
      idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/lpg_mux.sv
`timescale 1ns/1ps
module lpg_mux
  import lpg_pkg::*;
#(
  parameter int WORD_W_P = WORD_W
) (
  input  logic [2:0]          sel_i,
  input  logic [WORD_W_P-1:0] norm_i,
  input  logic [WORD_W_P-1:0] prbs_i,
  input  logic [WORD_W_P-1:0] shift_i,
  output logic [WORD_W_P-1:0] word_o
);
  always_comb begin
    case (sel_i)
      SRC_NORM:  word_o = norm_i;
      SRC_PRBS:  word_o = prbs_i;
      SRC_SHIFT: word_o = shift_i;
      default:   word_o = '0;
    endcase
  end
endmodule

// File: rtl/lane_pattern_gen.sv
`timescale 1ns/1ps
module lane_pattern_gen
  import lpg_pkg::*;
#(
  parameter int WORD_W_P = WORD_W,
  parameter int GROUPS   = 8,
  parameter int REP_W    = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [WORD_W_P-1:0]         norm_data,
  input  logic [2:0]                  src_sel,
  input  logic                        prbs_en,
  input  logic [1:0]                  prbs_mode,
  input  logic [1:0]                  prbs_width,
  input  logic                        shift_en,
  input  logic [REP_W-1:0]            shift_rep,
  input  logic [WORD_W_P*GROUPS-1:0]  shift_pat,
  output logic [WORD_W_P-1:0]         tx_word
);
  localparam int IDX_W = $clog2(GROUPS);

  // named internal events for the checker
  logic [WORD_W_P-1:0] prbs_word;
  logic [WORD_W_P-1:0] shift_word;
  logic [WORD_W_P-1:0] mux_word;
  logic [LFSR_W-1:0]   prbs_state;
  logic                prbs_step;
  logic [IDX_W-1:0]    shift_idx;
  logic [REP_W-1:0]    shift_cnt;
  logic                shift_adv;

  lpg_prbs #(.WORD_W_P(WORD_W_P)) u_prbs (
    .clk(clk), .rst_n(rst_n), .en_i(prbs_en), .mode_i(prbs_mode),
    .width_i(prbs_width), .word_o(prbs_word), .state_o(prbs_state),
    .step_o(prbs_step)
  );

  lpg_shift #(.WORD_W_P(WORD_W_P), .GROUPS(GROUPS), .REP_W(REP_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .en_i(shift_en), .rep_i(shift_rep),
    .pat_i(shift_pat), .word_o(shift_word), .idx_o(shift_idx),
    .cnt_o(shift_cnt), .adv_o(shift_adv)
  );

  lpg_mux #(.WORD_W_P(WORD_W_P)) u_mux (
    .sel_i(src_sel), .norm_i(norm_data), .prbs_i(prbs_word),
    .shift_i(shift_word), .word_o(mux_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) tx_word <= '0;
    else        tx_word <= mux_word;
  end
endmodule

// File: rtl/lpg_checker.sv
`timescale 1ns/1ps
module lpg_checker #(
  parameter int WORD_W_P = 10,
  parameter int REP_W    = 3,
  parameter int IDX_W    = 3,
  parameter int LFSR_W_P = 31
) (
  input logic                clk,
  input logic                rst_n,
  input logic [WORD_W_P-1:0] norm_data,
  input logic [2:0]          src_sel,
  input logic                prbs_en,
  input logic [1:0]          prbs_width,
  input logic                shift_en,
  input logic [WORD_W_P-1:0] tx_word,
  input logic [LFSR_W_P-1:0] prbs_state,
  input logic                prbs_step,
  input logic [IDX_W-1:0]    shift_idx,
  input logic                shift_adv
);
  assert_zero_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 3'b000) |=> (tx_word == '0));

  assert_norm_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 3'b001) |=> (tx_word == $past(norm_data)));

  assert_bad_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$onehot0(src_sel)) |=> (tx_word == '0));

  assert_byte_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 3'b010 && prbs_width == 2'd1) |=> (tx_word[WORD_W_P-1:8] == '0));

  assert_bit_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 3'b010 && prbs_width == 2'd2) |=> (tx_word[WORD_W_P-1:1] == '0));

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (prbs_en && !prbs_step) |=> $stable(prbs_state));

  assert_prbs_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 3'b010 && !prbs_en) |=> (tx_word == '0));

  assert_group_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    shift_adv |=> (shift_idx == IDX_W'($past(shift_idx) + 1'b1)));

  assert_group_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !shift_adv) |=> $stable(shift_idx));

  assert_shift_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 3'b100 && !shift_en) |=> (tx_word == '0));
endmodule

bind lane_pattern_gen lpg_checker #(
  .WORD_W_P(WORD_W_P), .REP_W(REP_W), .IDX_W(IDX_W), .LFSR_W_P(lpg_pkg::LFSR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .norm_data(norm_data), .src_sel(src_sel),
  .prbs_en(prbs_en), .prbs_width(prbs_width), .shift_en(shift_en),
  .tx_word(tx_word), .prbs_state(prbs_state), .prbs_step(prbs_step),
  .shift_idx(shift_idx), .shift_adv(shift_adv)
);

// File: tb/sim_lane_pattern_gen.sv
`timescale 1ns/1ps
module sim_lane_pattern_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [9:0]  norm_data;
  logic [2:0]  src_sel;
  logic        prbs_en;
  logic [1:0]  prbs_mode;
  logic [1:0]  prbs_width;
  logic        shift_en;
  logic [2:0]  shift_rep;
  logic [79:0] shift_pat;
  logic [9:0]  tx_word;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic stream [0:127];

  always #5 clk = ~clk;

  lane_pattern_gen u0 (
    .clk(clk), .rst_n(rst_n), .norm_data(norm_data), .src_sel(src_sel),
    .prbs_en(prbs_en), .prbs_mode(prbs_mode), .prbs_width(prbs_width),
    .shift_en(shift_en), .shift_rep(shift_rep), .shift_pat(shift_pat),
    .tx_word(tx_word)
  );

  // {src_sel, norm_data, expected tx_word}, generators disabled (R2)
  localparam logic [22:0] VEC [12] = '{
    {3'b001, 10'h3FF, 10'h3FF}, {3'b001, 10'h155, 10'h155},
    {3'b000, 10'h2AA, 10'h000}, {3'b001, 10'h001, 10'h001},
    {3'b011, 10'h1F0, 10'h000}, {3'b101, 10'h0F1, 10'h000},
    {3'b110, 10'h37C, 10'h000}, {3'b111, 10'h2B3, 10'h000},
    {3'b010, 10'h0AA, 10'h000}, {3'b100, 10'h3C3, 10'h000},
    {3'b001, 10'h200, 10'h200}, {3'b001, 10'h000, 10'h000}
  };

  task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // serial reference: b[k] = b[k-L] ^ b[k-T], negative indices are 1 (R3)
  task automatic build_stream(input int m);
    int l;
    int t;
    logic a;
    logic b;
    case (m)
      0: begin l = 11; t = 9;  end
      1: begin l = 15; t = 14; end
      2: begin l = 7;  t = 6;  end
      default: begin l = 31; t = 28; end
    endcase
    for (int k = 0; k < 128; k++) begin
      a = (k - l < 0) ? 1'b1 : stream[k-l];
      b = (k - t < 0) ? 1'b1 : stream[k-t];
      stream[k] = a ^ b;
    end
  endtask

  function automatic int bits_for(input int w);
    return (w == 1) ? 8 : (w == 2) ? 1 : (w == 3) ? 10 : 0;
  endfunction

  function automatic logic [9:0] take(input int pos, input int n);
    logic [9:0] v = '0;
    for (int i = 0; i < n; i++) v[i] = stream[pos+i];
    return v;
  endfunction

  function automatic logic [9:0] grp_val(input int g);
    return 10'((10'h2C7 ^ (g * 97)) & 10'h3FF);
  endfunction

  task automatic run_prbs(input int m, input int w, input int n);
    int pos = 0;
    @(negedge clk);
    prbs_en = 1'b0; prbs_mode = 2'(m); prbs_width = 2'(w); src_sel = 3'b010;
    @(negedge clk);
    chk("R5 disabled word", tx_word, 10'h000);
    prbs_en = 1'b1;
    build_stream(m);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      chk($sformatf("R3 R4 mode%0d width%0d word%0d", m, w, c), tx_word, take(pos, bits_for(w)));
      pos += bits_for(w);
    end
  endtask

  task automatic run_shift(input int r, input int n);
    @(negedge clk);
    shift_en = 1'b0; shift_rep = 3'(r); src_sel = 3'b100;
    @(negedge clk);
    chk("R8 disabled word", tx_word, 10'h000);
    shift_en = 1'b1;
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      chk($sformatf("R6 R7 rep%0d cycle%0d", r, j), tx_word, grp_val((j / (r + 1)) % 8));
    end
  endtask

  initial begin
    rst_n = 1'b0; norm_data = 10'h155; src_sel = 3'b001; prbs_en = 1'b0;
    prbs_mode = '0; prbs_width = '0; shift_en = 1'b0; shift_rep = '0;
    for (int g = 0; g < 8; g++) shift_pat[79-10*g -: 10] = grp_val(g);
    repeat (3) @(negedge clk);
    chk("R1 in reset", tx_word, 10'h000);
    src_sel = 3'b000;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", tx_word, 10'h000);

    // table walk over selector codes (R2)
    for (int v = 0; v < 12; v++) begin
      src_sel = VEC[v][22:20]; norm_data = VEC[v][19:10];
      @(negedge clk);
      chk($sformatf("R2 vector%0d", v), tx_word, VEC[v][9:0]);
    end

    // every polynomial at every width
    for (int m = 0; m < 4; m++)
      for (int w = 1; w < 4; w++)
        run_prbs(m, w, 6);

    // idle width outputs zero and holds the stream (R4)
    prbs_en = 1'b0; prbs_mode = 2'd0; prbs_width = 2'd0; src_sel = 3'b010;
    @(negedge clk);
    prbs_en = 1'b1;
    build_stream(0);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk("R4 idle width", tx_word, 10'h000);
    end
    prbs_width = 2'd3;
    @(negedge clk);
    chk("R4 no advance while idle", tx_word, take(0, 10));

    // generator runs while unselected (R9)
    prbs_en = 1'b0; prbs_mode = 2'd2; prbs_width = 2'd3; src_sel = 3'b000;
    @(negedge clk);
    prbs_en = 1'b1;
    build_stream(2);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk("R9 unselected zero", tx_word, 10'h000);
    end
    src_sel = 3'b010;
    @(negedge clk);
    chk("R9 stream continued", tx_word, take(30, 10));
    prbs_en = 1'b0;

    // rotating pattern with several hold counts, across the wrap
    run_shift(0, 18);
    run_shift(2, 27);
    run_shift(7, 70);

    // restart at group 0 after a disable (R8)
    run_shift(1, 5);
    shift_en = 1'b0;
    @(negedge clk);
    chk("R8 off mid-pattern", tx_word, 10'h000);
    shift_en = 1'b1;
    @(negedge clk);
    chk("R8 restart group0", tx_word, grp_val(0));
    @(negedge clk);
    chk("R8 restart hold", tx_word, grp_val(0));

    // shift generator advances while unselected (R9)
    shift_en = 1'b0; shift_rep = 3'd0; src_sel = 3'b000;
    @(negedge clk);
    shift_en = 1'b1;
    repeat (3) @(negedge clk);
    src_sel = 3'b100;
    @(negedge clk);
    chk("R9 shift unselected", tx_word, grp_val(3));

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule